// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit-rate timing for one serial channel. It counts ticks from one of two clock-enable sources, either the system tick or a tick brought in from an external clock pin. A 16-bit time constant TC sets the count. Each half of the output period lasts TC+2 source ticks, so the baud rate is f/(2·(TC+2)). Software obtains TC from a target rate as (f+bps)/(2·bps) − 2.

Each half-period boundary gives a zero-count pulse for the channel's status logic. A gated copy of that pulse serves as an interrupt request. Each full period gives a baud tick. A sampling prescaler follows the baud tick and passes one bit tick for every 1, 16, 32 or 64 baud ticks. The live count value is brought out so that software can read it back.

Configuration uses a byte-wide write port with a 2-bit register select:

| Select | Contents |
|---|---|
| 0 | TC low byte |
| 1 | TC high byte |
| 2 | Control |
| 3 | Prescaler mode |

Top module: `baud_gen`

## Requirements
- R1: After reset, `cur_count` is 0 and `zc_pulse`, `zc_irq`, `baud_tick` and `bit_tick` are all low.
- R2: The time constant is built from two byte writes: select 0 writes TC[7:0] and select 1 writes TC[15:8].
- R3: While the generator is enabled, the Nth selected source tick after reset produces a one-cycle `zc_pulse` exactly when N is a multiple of TC+2. It produces a one-cycle `baud_tick` exactly when N is a multiple of 2·(TC+2). Both appear in the clock cycle after the tick.
- R4: `cur_count` reads TC after the first tick of each half period. It then falls by one per tick to 0. It holds 0 for one further tick, which is the tick that raises `zc_pulse`.
- R5: Control bit 0 enables counting. While it is 0, `cur_count` is frozen and no pulses occur. When it is set again, counting resumes from the frozen value.
- R6: Control bit 1 selects the source. A value of 1 selects `sys_tick` and 0 selects `ext_tick`. Ticks on the unselected input have no effect.
- R7: A new time constant written mid-period does not change the half period in progress. It takes effect at the next reload.
- R8: `zc_irq` pulses together with `zc_pulse` when control bit 2 is 1, and stays low when that bit is 0.
- R9: Mode register bits 7:6 select the prescaler ratio: 00 gives ×1, 01 gives ×16, 10 gives ×32 and 11 gives ×64. `bit_tick` pulses with every ratio-th `baud_tick`. Writing the mode register restarts the prescaler count.
- R10: TC = 0 gives the shortest period: a `zc_pulse` every 2 ticks and a `baud_tick` every 4 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 TC low, 1 TC high, 2 control, 3 mode) |
| wr_data | input | 8 | Write data byte |
| sys_tick | input | 1 | System clock enable source |
| ext_tick | input | 1 | External pin clock enable source (already synchronized) |
| baud_tick | output | 1 | One pulse per full output period |
| bit_tick | output | 1 | Baud tick after the ×1/16/32/64 prescaler |
| zc_pulse | output | 1 | Zero-count event, one per half period |
| zc_irq | output | 1 | Zero-count pulse gated by the interrupt enable |
| cur_count | output | 16 | Current down-counter value |

## Verification
Each pulse output is registered once after the counter edge that consumes a tick. A tick driven on a falling edge therefore shows its `zc_pulse`, `zc_irq`, `baud_tick` and `bit_tick` at the next falling edge. At that same falling edge `cur_count` already shows its new value. The bench drives inputs and samples outputs only on falling edges, and it samples before it drives. Every observation is therefore tied to the one tick it follows. The expected values come from a running tick index taken modulo TC+2, 2·(TC+2) and the prescaler ratio. Register writes are only made in cycles that carry no tick.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    SEL_TC_LO = 2'd0,
    SEL_TC_HI = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SYS_BIT = 1;
  localparam int CTRL_IRQ_BIT = 2;
  localparam int MODE_LSB     = 6;
  localparam int MAX_RATIO    = 64;

  // Source ticks spent in one half of the output period.
  function automatic int unsigned half_ticks(int unsigned tc);
    return tc + 2;
  endfunction

  // Prescaler ratio selected by the two mode bits.
  function automatic int unsigned mode_ratio(logic [1:0] m);
    case (m)
      2'b00:   return 1;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/baud_gen_regs.sv
module baud_gen_regs
  import baud_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  tc,
  output logic              run_en,
  output logic              src_sys,
  output logic              irq_en,
  output logic [1:0]        mode,
  output logic              mode_wr
);

  logic [DATA_W-1:0] tc_lo_q, tc_hi_q;
  logic [2:0]        ctrl_q;
  logic [1:0]        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_lo_q <= '0;
      tc_hi_q <= '0;
      ctrl_q  <= '0;
      mode_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_TC_LO: tc_lo_q <= wr_data;
        SEL_TC_HI: tc_hi_q <= wr_data;
        SEL_CTRL:  ctrl_q  <= wr_data[2:0];
        SEL_MODE:  mode_q  <= wr_data[MODE_LSB+1:MODE_LSB];
        default:   ;
      endcase
    end
  end

  assign tc      = {tc_hi_q, tc_lo_q};
  assign run_en  = ctrl_q[CTRL_RUN_BIT];
  assign src_sys = ctrl_q[CTRL_SYS_BIT];
  assign irq_en  = ctrl_q[CTRL_IRQ_BIT];
  assign mode    = mode_q;
  assign mode_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);

  // R2: a low-byte write leaves the high byte untouched
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_TC_LO) |=> $stable(tc[CNT_W-1:DATA_W]));

endmodule

// File: rtl/baud_gen_counter.sv
module baud_gen_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             src_tick,
  input  logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt,
  output logic             full_evt,
  output logic             zc_pulse,
  output logic             baud_tick
);

  logic [CNT_W-1:0] count_q;
  logic             hold_q;   // zero reached, reload due on next tick
  logic             lvl_q;    // output level, toggles every half period
  logic             step;

  assign step     = src_tick && run_en;
  assign zero_evt = step && (count_q == '0) && !hold_q;
  assign full_evt = zero_evt && lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      hold_q    <= 1'b1;
      lvl_q     <= 1'b0;
      zc_pulse  <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      zc_pulse  <= zero_evt;
      baud_tick <= full_evt;
      if (step) begin
        if (count_q != '0) begin
          count_q <= count_q - 1'b1;
        end else if (hold_q) begin
          count_q <= tc;
          hold_q  <= 1'b0;
        end else begin
          hold_q <= 1'b1;
          lvl_q  <= ~lvl_q;
        end
      end
    end
  end

  assign count = count_q;

  // R5: with the generator disabled the count does not move and no event occurs
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(count_q) && !zc_pulse));

  // R7: a reload takes whatever time constant is present at that tick
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q == '0 && hold_q) |=> (count_q == $past(tc)));

  // R4: a non-zero count steps down by one per tick
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

  // R3: a zero-count pulse only follows a zero count
  a_r3_zc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> (count_q == '0));

endmodule

// File: rtl/baud_gen_prescaler.sv
module baud_gen_prescaler
  import baud_gen_pkg::*;
#(
  parameter int RATIO_MAX = MAX_RATIO,
  localparam int PRE_W = $clog2(RATIO_MAX)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_evt,
  input  logic [1:0] mode,
  input  logic       clear,
  output logic       bit_tick
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] last;
  logic             wrap;

  assign last = PRE_W'(mode_ratio(mode) - 1);
  assign wrap = full_evt && (pcnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= wrap && !clear;
      if (clear || wrap) pcnt_q <= '0;
      else if (full_evt) pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R9: a mode write restarts the prescaler from zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pcnt_q == '0 && !bit_tick));

  // R9: the prescaler count never passes the selected ratio
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode) |-> (pcnt_q <= last));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sys_tick,
  input  logic              ext_tick,
  output logic              baud_tick,
  output logic              bit_tick,
  output logic              zc_pulse,
  output logic              zc_irq,
  output logic [CNT_W-1:0]  cur_count
);

  logic [CNT_W-1:0] tc;
  logic             run_en, src_sys, irq_en, mode_wr;
  logic [1:0]       mode;
  logic             src_tick, zero_evt, full_evt;

  baud_gen_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tc(tc), .run_en(run_en), .src_sys(src_sys), .irq_en(irq_en),
    .mode(mode), .mode_wr(mode_wr)
  );

  assign src_tick = src_sys ? sys_tick : ext_tick;

  baud_gen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_tick(src_tick), .tc(tc),
    .count(cur_count), .zero_evt(zero_evt), .full_evt(full_evt),
    .zc_pulse(zc_pulse), .baud_tick(baud_tick)
  );

  baud_gen_prescaler #(.RATIO_MAX(MAX_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .full_evt(full_evt), .mode(mode),
    .clear(mode_wr), .bit_tick(bit_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_irq <= 1'b0;
    else        zc_irq <= zero_evt && irq_en;
  end

  // R8: an interrupt request never appears without its zero-count pulse
  a_r8_irq_with_zc: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> zc_pulse);

  // R3: a baud tick marks a half-period boundary
  a_r3_baud_on_zc: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> zc_pulse);

  // R9: prescaled ticks are a subset of baud ticks
  a_r9_bit_on_baud: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> baud_tick);

  // R3: consecutive zero-count pulses are at least two cycles apart
  a_r3_zc_single: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |=> !zc_pulse);

endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        sys_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        baud_tick, bit_tick, zc_pulse, zc_irq;
  logic [15:0] cur_count;

  baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sys_tick(sys_tick), .ext_tick(ext_tick), .baud_tick(baud_tick),
    .bit_tick(bit_tick), .zc_pulse(zc_pulse), .zc_irq(zc_irq), .cur_count(cur_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // bench model state
  int  m_tc, m_div, m_pre_org, m_tick_n;
  bit  m_sys, m_irq;

  function automatic int ratio_of(int m);
    return (m == 0) ? 1 : (8 << m);
  endfunction

  function automatic int exp_count(int tc, int n);
    int p;
    p = n % (tc + 2);
    return (p == 0) ? 0 : tc + 1 - p;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sys_tick = 1'b0; ext_tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_tick_n = 0; m_pre_org = 0;
  endtask

  task automatic setup(int tc, int mode, bit sys, bit irq);
    do_reset();
    m_tc = tc; m_div = ratio_of(mode); m_sys = sys; m_irq = irq;
    wr(0, tc & 8'hff);
    wr(1, (tc >> 8) & 8'hff);
    wr(3, mode << 6);
    wr(2, {5'b0, irq, sys, 1'b1});
  endtask

  // Drive n selected ticks (with random gaps if sparse) and compare every cycle.
  task automatic run(int n, bit sparse);
    int sent = 0;
    bit last = 0;
    int e_zc = 0, e_bd = 0, e_bt = 0, e_ct = 0, e_irq = 0;
    int hp = m_tc + 2;
    while (sent < n || last) begin
      bit t, noise, xz, xb, xt;
      @(negedge clk);
      xz = last && (m_tick_n % hp == 0);
      xb = last && (m_tick_n % (2*hp) == 0);
      xt = xb && ((m_tick_n - m_pre_org) % (2*hp*m_div) == 0);
      if (zc_pulse !== xz) e_zc++;
      if (baud_tick !== xb) e_bd++;
      if (bit_tick !== xt) e_bt++;
      if (zc_irq !== (xz && m_irq)) e_irq++;
      if (int'(cur_count) != exp_count(m_tc, m_tick_n)) e_ct++;
      t = (sent < n) && (!sparse || ($urandom_range(0, 3) != 0));
      noise = ($urandom_range(0, 1) == 1);
      if (m_sys) begin sys_tick = t; ext_tick = noise; end
      else       begin ext_tick = t; sys_tick = noise; end
      if (t) begin sent++; m_tick_n++; end
      last = t;
    end
    sys_tick = 1'b0; ext_tick = 1'b0;
    check(e_zc == 0, "R3 zc_pulse timing mismatches", e_zc, 0);
    check(e_bd == 0, "R3 baud_tick timing mismatches", e_bd, 0);
    check(e_bt == 0, "R9 bit_tick timing mismatches", e_bt, 0);
    check(e_ct == 0, "R4 cur_count mismatches", e_ct, 0);
    check(e_irq == 0, "R8 zc_irq mismatches", e_irq, 0);
  endtask

  // One tick on the chosen line; returns what the outputs show after it.
  task automatic tick_once(bit on_sys, output bit zc, output int cnt);
    @(negedge clk);
    if (on_sys) sys_tick = 1'b1; else ext_tick = 1'b1;
    @(negedge clk);
    sys_tick = 1'b0; ext_tick = 1'b0;
    zc = zc_pulse; cnt = int'(cur_count);
  endtask

  initial begin
    bit zc;
    int cnt, first, second, nzc, bad;
    process::self().srandom(32'd1234);

    // R1 reset state
    do_reset();
    @(negedge clk);
    check(cur_count == 16'd0, "R1 count after reset", int'(cur_count), 0);
    check({zc_pulse, zc_irq, baud_tick, bit_tick} == 4'b0, "R1 pulses after reset",
          int'({zc_pulse, zc_irq, baud_tick, bit_tick}), 0);

    // R3/R4/R6/R8/R9 random configurations
    for (int s = 0; s < 6; s++) begin
      setup($urandom_range(0, 30), $urandom_range(0, 3), s[0], s[1]);
      run(600, 1'b1);
    end

    // R2 high byte: TC = 0x0102
    setup(16'h0102, 0, 1'b1, 1'b1);
    tick_once(1'b1, zc, cnt);
    check(cnt == 16'h0102, "R2 two-byte time constant loaded", cnt, 16'h0102);
    m_tick_n = 1;
    run(600, 1'b0);

    // R10 shortest period
    setup(0, 0, 1'b1, 1'b0);
    run(40, 1'b0);

    // R9 each prescaler ratio with TC = 0
    for (int m = 0; m < 4; m++) begin
      setup(0, m, 1'b1, 1'b0);
      run(512, 1'b0);
    end

    // R9 mode rewrite restarts the prescaler
    setup(0, 1, 1'b1, 1'b0);
    run(12, 1'b0);
    wr(3, 1 << 6);
    m_pre_org = 12;
    run(80, 1'b0);

    // R6 unselected source ignored
    setup(3, 0, 1'b0, 1'b0);
    nzc = 0;
    for (int i = 0; i < 30; i++) begin
      tick_once(1'b1, zc, cnt);
      if (zc || cnt != 0) nzc++;
    end
    check(nzc == 0, "R6 sys_tick ignored when ext selected", nzc, 0);
    tick_once(1'b0, zc, cnt);
    check(cnt == 3, "R6 ext_tick drives the count", cnt, 3);

    // R7 new TC applies at the next reload
    setup(5, 0, 1'b1, 1'b0);
    for (int i = 1; i <= 3; i++) tick_once(1'b1, zc, cnt);
    wr(0, 2);
    first = 0; second = 0;
    for (int i = 4; i <= 15; i++) begin
      tick_once(1'b1, zc, cnt);
      if (zc && first == 0) first = i;
      else if (zc && second == 0) second = i;
    end
    check(first == 7, "R7 old TC finishes current half", first, 7);
    check(second == 11, "R7 new TC used after reload", second, 11);

    // R5 freeze and resume
    setup(9, 0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) tick_once(1'b1, zc, cnt);
    check(cnt == 6, "R5 count before freeze", cnt, 6);
    wr(2, 8'h02);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick_once(1'b1, zc, cnt);
      if (zc || cnt != 6) bad++;
    end
    check(bad == 0, "R5 count frozen while disabled", bad, 0);
    wr(2, 8'h03);
    first = 0;
    for (int i = 5; i <= 12; i++) begin
      tick_once(1'b1, zc, cnt);
      if (zc && first == 0) first = i;
    end
    check(first == 11, "R5 resume keeps frozen position", first, 11);

    summary();
    $finish;
  end
endmodule